// File: doc/BRIEF.md
# Calibration Limit Latch and Checker

This block holds the four 5-bit detection thresholds of a smoke sensing front end: normal, hysteresis, hush and chamber-test. The calibration sequence walks through numbered modes. In modes 1 to 4, a rising edge on the latch strobe copies the present digitised level into the staging slot for that mode's threshold. The staged values do nothing until a rising edge on program-enable in mode 5. That edge commits all four staged thresholds to the stored set, and at the same edge it records the present level as a 5-bit drift baseline.

In modes 7 to 10, the block compares a measured level against one stored threshold: mode 7 uses normal, 8 uses hysteresis, 9 uses hush and 10 uses chamber-test. The result and its valid flag are registered when a measurement completes while measure-enable is high. Both clear as soon as the mode changes or measure-enable drops. Stored thresholds reset to the maximum code, so a part that has not been calibrated never reports a pass.

Top module: `cal_limit_unit`

## Requirements
- R1: After reset, cmpValid, cmpOut and baseOut are all 0.
- R2: In modes 1, 2, 3 and 4, a rising edge of latchStrobe captures levelIn into the staging slot for normal, hysteresis, hush or chamber-test respectively. In any other mode, latchStrobe has no effect.
- R3: A staged threshold does not affect comparisons until it is committed.
- R4: In mode 5, a rising edge of progEn copies all four staged thresholds into the stored set and loads levelIn into baseOut. Both updates land on the same clock edge.
- R5: A progEn edge in any mode other than 5 changes neither the stored thresholds nor baseOut.
- R6: Modes 7, 8, 9 and 10 compare against the stored normal, hysteresis, hush and chamber-test thresholds respectively.
- R7: When a result is captured, cmpOut is 1 if levelIn is strictly greater than the selected threshold, and 0 if it is equal or lower. cmpOut is never 1 while cmpValid is 0.
- R8: cmpValid and cmpOut update one clock after a cycle in which measDone and measEn are both 1 in a check mode and the mode did not change.
- R9: cmpValid and cmpOut go to 0 one clock after a cycle in which measEn is 0 or modeSel differs from its previous value.
- R10: measDone has no effect outside modes 7 to 10 or while measEn is 0.
- R11: The stored thresholds reset to 31, so no level reports a pass before the first commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 4 | Current calibration/test mode number |
| latchStrobe | input | 1 | Captures the level into staging (edge-sensitive) |
| progEn | input | 1 | Commits staged thresholds and baseline (edge-sensitive) |
| measEn | input | 1 | Measurement enable |
| measDone | input | 1 | Measurement completion flag |
| levelIn | input | 5 | Current digitised level |
| cmpOut | output | 1 | Comparison result: level above threshold |
| cmpValid | output | 1 | Comparison result is valid |
| baseOut | output | 5 | Stored drift baseline |

## Verification
The assertions check the timing of the result flag on every cycle. They confirm that the flag drops after a mode change or after measure-enable goes low, that it rises only after a completed measurement with measure-enable high, and that the result bit never stands without the flag. They also confirm that the baseline holds in every cycle without a program-enable in mode 5. What the assertions cannot show, the bench scenarios cover: which threshold each check mode selects, the strict comparison at the equal code, and the staging-then-commit sequence in which latched values stay invisible until the commit. They also cover how strobes in foreign modes are ignored.

// File: rtl/cal_limit_pkg.sv
package cal_limit_pkg;
  parameter int LIM_W   = 5;
  parameter int NUM_LIM = 4;
  parameter int SEL_W   = $clog2(NUM_LIM);

  typedef struct packed {
    logic [NUM_LIM-1:0] latchHot;
    logic               commit;
    logic               measCapture;
    logic               clearRes;
    logic [SEL_W-1:0]   checkSel;
  } ctrl_strobe_t;
endpackage

// File: rtl/cal_limit_ctrl.sv
module cal_limit_ctrl
  import cal_limit_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int LATCH_BASE  = 1,
  parameter int COMMIT_MODE = 5,
  parameter int CHECK_BASE  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              latchStrobe,
  input  logic              progEn,
  input  logic              measEn,
  input  logic              measDone,
  output ctrl_strobe_t      strobes
);
  logic [MODE_W-1:0] prevMode;
  logic prevLatch, prevProg;
  logic modeChg, latchRise, progRise, inCheck;
  logic [SEL_W-1:0] sel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMode  <= '0;
      prevLatch <= 1'b0;
      prevProg  <= 1'b0;
    end else begin
      prevMode  <= modeSel;
      prevLatch <= latchStrobe;
      prevProg  <= progEn;
    end
  end

  always_comb begin
    modeChg   = (modeSel != prevMode);
    latchRise = latchStrobe & ~prevLatch;
    progRise  = progEn & ~prevProg;
    inCheck   = 1'b0;
    sel       = '0;
    for (int i = 0; i < NUM_LIM; i++) begin
      if (modeSel == MODE_W'(CHECK_BASE + i)) begin
        inCheck = 1'b1;
        sel     = SEL_W'(i);
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_LIM; i++) begin
      strobes.latchHot[i] = latchRise && (modeSel == MODE_W'(LATCH_BASE + i));
    end
    strobes.commit      = progRise && (modeSel == MODE_W'(COMMIT_MODE));
    strobes.clearRes    = modeChg | ~measEn;
    strobes.measCapture = inCheck & measEn & measDone & ~modeChg;
    strobes.checkSel    = sel;
  end
endmodule

// File: rtl/cal_limit_data.sv
module cal_limit_data
  import cal_limit_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrl_strobe_t     strobes,
  input  logic [LIM_W-1:0] levelIn,
  output logic             cmpOut,
  output logic             cmpValid,
  output logic [LIM_W-1:0] baseOut
);
  localparam logic [LIM_W-1:0] LIM_RESET = '1;

  logic [LIM_W-1:0] stageLim  [NUM_LIM];
  logic [LIM_W-1:0] storedLim [NUM_LIM];
  logic [LIM_W-1:0] selLim;
  logic             aboveLim;

  for (genvar g = 0; g < NUM_LIM; g++) begin : g_slot
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageLim[g]  <= LIM_RESET;
        storedLim[g] <= LIM_RESET;
      end else begin
        if (strobes.latchHot[g]) stageLim[g] <= levelIn;
        if (strobes.commit)      storedLim[g] <= stageLim[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               baseOut <= '0;
    else if (strobes.commit) baseOut <= levelIn;
  end

  always_comb begin
    selLim   = storedLim[strobes.checkSel];
    aboveLim = (levelIn > selLim);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpOut   <= 1'b0;
      cmpValid <= 1'b0;
    end else if (strobes.clearRes) begin
      cmpOut   <= 1'b0;
      cmpValid <= 1'b0;
    end else if (strobes.measCapture) begin
      cmpOut   <= aboveLim;
      cmpValid <= 1'b1;
    end
  end
endmodule

// File: rtl/cal_limit_unit.sv
module cal_limit_unit
  import cal_limit_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int LATCH_BASE  = 1,
  parameter int COMMIT_MODE = 5,
  parameter int CHECK_BASE  = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              latchStrobe,
  input  logic              progEn,
  input  logic              measEn,
  input  logic              measDone,
  input  logic [LIM_W-1:0]  levelIn,
  output logic              cmpOut,
  output logic              cmpValid,
  output logic [LIM_W-1:0]  baseOut
);
  ctrl_strobe_t strobes;

  cal_limit_ctrl #(
    .MODE_W(MODE_W), .LATCH_BASE(LATCH_BASE),
    .COMMIT_MODE(COMMIT_MODE), .CHECK_BASE(CHECK_BASE)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .latchStrobe(latchStrobe),
    .progEn(progEn), .measEn(measEn), .measDone(measDone), .strobes(strobes)
  );

  cal_limit_data u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .levelIn(levelIn),
    .cmpOut(cmpOut), .cmpValid(cmpValid), .baseOut(baseOut)
  );
endmodule

// File: rtl/cal_limit_chk.sv
module cal_limit_chk
  import cal_limit_pkg::*;
#(
  parameter int MODE_W      = 4,
  parameter int COMMIT_MODE = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic [MODE_W-1:0] modeSel,
  input logic              progEn,
  input logic              measEn,
  input logic              measDone,
  input logic              cmpOut,
  input logic              cmpValid,
  input logic [LIM_W-1:0]  baseOut
);
  AST_OUT_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rstN)
    cmpOut |-> cmpValid); // R7
  AST_VALID_FROM_MEAS: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cmpValid) |-> $past(measDone && measEn)); // R8
  AST_CLEAR_ON_MEASEN: assert property (@(posedge clk) disable iff (!rstN)
    !measEn |=> !cmpValid); // R9
  AST_CLEAR_ON_MODE: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(modeSel) |=> !cmpValid); // R9
  AST_BASE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !(progEn && modeSel == MODE_W'(COMMIT_MODE)) |=> $stable(baseOut)); // R5
endmodule

bind cal_limit_unit cal_limit_chk #(.MODE_W(MODE_W), .COMMIT_MODE(COMMIT_MODE)) u_chk (
  .clk(clk), .rstN(rstN), .modeSel(modeSel), .progEn(progEn), .measEn(measEn),
  .measDone(measDone), .cmpOut(cmpOut), .cmpValid(cmpValid), .baseOut(baseOut)
);

// File: tb/cal_limit_unit_test.sv
`timescale 1ns/1ps
module cal_limit_unit_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] modeSel = '0;
  logic       latchStrobe = 1'b0, progEn = 1'b0, measEn = 1'b0, measDone = 1'b0;
  logic [4:0] levelIn = '0;
  logic       cmpOut, cmpValid;
  logic [4:0] baseOut;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cal_limit_unit uut (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .latchStrobe(latchStrobe),
    .progEn(progEn), .measEn(measEn), .measDone(measDone), .levelIn(levelIn),
    .cmpOut(cmpOut), .cmpValid(cmpValid), .baseOut(baseOut)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic setMode(int m);
    @(negedge clk); modeSel = 4'(m);
    @(negedge clk); @(negedge clk);
  endtask

  task automatic pulseLatch(int lvl);
    @(negedge clk); levelIn = 5'(lvl); latchStrobe = 1'b1;
    @(negedge clk); latchStrobe = 1'b0;
  endtask

  task automatic pulseProg(int lvl);
    @(negedge clk); levelIn = 5'(lvl); progEn = 1'b1;
    @(negedge clk); progEn = 1'b0;
  endtask

  task automatic measure(string req, int lvl, int expOut);
    @(negedge clk); levelIn = 5'(lvl); measDone = 1'b1;
    @(negedge clk); measDone = 1'b0;
    check({req, " valid"}, int'(cmpValid), 1);
    check({req, " out"}, int'(cmpOut), expOut);
  endtask

  task automatic t_reset;
    check("R1 valid", int'(cmpValid), 0);
    check("R1 out", int'(cmpOut), 0);
    check("R1 base", int'(baseOut), 0);
    measEn = 1'b1;
    setMode(7);
    measure("R11 max level vs reset limit", 31, 0);
    setMode(10);
    measure("R11 chamber reset limit", 31, 0);
  endtask

  task automatic t_latchCommit;
    setMode(1); pulseLatch(10);
    setMode(2); pulseLatch(12);
    setMode(3); pulseLatch(14);
    setMode(4); pulseLatch(16);
    setMode(7);
    measure("R3 staged not yet used", 20, 0);
    setMode(5); pulseProg(9);
    check("R4 baseline captured", int'(baseOut), 9);
    setMode(7);
    measure("R7 above normal", 11, 1);
    measure("R7 equal normal", 10, 0);
    measure("R7 below normal", 9, 0);
    setMode(8);
    measure("R6 hysteresis above", 13, 1);
    measure("R6 hysteresis equal", 12, 0);
    setMode(9);
    measure("R6 hush above", 15, 1);
    measure("R6 hush equal", 14, 0);
    setMode(10);
    measure("R6 chamber above", 17, 1);
    measure("R6 chamber equal", 16, 0);
  endtask

  task automatic t_ignored;
    setMode(6); pulseLatch(1);
    setMode(5); pulseProg(9);
    setMode(7);
    measure("R2 latch in mode 6 ignored", 11, 1);
    setMode(0); pulseProg(3);
    check("R5 baseline kept", int'(baseOut), 9);
    setMode(1); pulseLatch(2);
    setMode(6); pulseProg(4);
    check("R5 baseline kept mode 6", int'(baseOut), 9);
    setMode(7);
    measure("R5 no commit outside mode 5", 5, 0);
    measure("R2 limit still 10", 11, 1);
  endtask

  task automatic t_validClear;
    @(negedge clk); measEn = 1'b0;
    @(negedge clk);
    check("R9 clear on measEn low", int'(cmpValid), 0);
    check("R9 out cleared", int'(cmpOut), 0);
    @(negedge clk); levelIn = 5'd31; measDone = 1'b1;
    @(negedge clk); measDone = 1'b0;
    check("R10 measDone ignored measEn low", int'(cmpValid), 0);
    measEn = 1'b1;
    measure("R8 valid after measurement", 31, 1);
    @(negedge clk); modeSel = 4'd8;
    @(negedge clk);
    check("R9 clear on mode change", int'(cmpValid), 0);
    setMode(6);
    @(negedge clk); measDone = 1'b1;
    @(negedge clk); measDone = 1'b0;
    check("R10 measDone ignored mode 6", int'(cmpValid), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_latchCommit();
    t_ignored();
    t_validClear();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule